// File: doc/BRIEF.md
# Shared-Connector Routing Mode Controller

This block turns a two-bit control code into one of five routing modes for a connector that carries either stereo audio or one of two USB data paths. The modes are all-off, USB path 1, USB path 2, audio and audio mute. The block drives one enable for each USB path, one enable for the audio path and one enable for the shunt that loads the output lines while audio is muted. Each enable is meant to drive a switch.

Two bits cannot name five modes on their own. Code `10` is therefore resolved by a one-bit history register. That bit is set when audio or mute is entered and cleared when any other mode is entered. While it is set, `10` means mute. While it is clear, `10` means USB path 2.

The two control bits may change a little apart, so the controller waits for a code to stay steady for a skew window before it acts on it. Every mode change is break-before-make. All enables drop first. They stay low for a break interval and then for an entry delay that depends on the transition. Only then does the new enable rise. A code that becomes steady while a change is still in progress is held and applied as soon as that change completes. The control pads carry pull-downs outside this block, so an undriven input arrives here as 0.

Top module: `conn_mode_ctrl`

## Requirements
- R1: After reset, all four enables are low, `mode_o` is 0 (all-off), `busy_o` is low and the history bit is clear.
- R2: Mode encodings on `mode_o`: 0 all-off, 1 USB path 1, 2 USB path 2, 3 audio, 4 mute. Code bits `{ctl_i[1],ctl_i[0]}` select all-off for `00`, USB path 1 for `01` and audio for `11`. Each of these modes raises only its own enable: `usb1_en_o`, `audio_en_o`, or none for all-off.
- R3: Code `10` selects mute when the last mode entered was audio or mute. It selects USB path 2 (`usb2_en_o`) when the last mode entered was all-off, USB path 1 or USB path 2. Holding `10` while in mute keeps mute.
- R4: `shunt_en_o` is high only in mute, and at most one of the four enables is high at any time.
- R5: A code takes effect only after the synchronized code has been equal on SKEW_CYC+1 consecutive clocks. A code held for fewer clocks is ignored, and so is an intermediate code seen during a skewed two-bit change.
- R6: When a change is committed, all enables go low and `busy_o` rises on the same clock. The new enable rises, and `busy_o` falls, BREAK_CYC plus the entry delay clocks later.
- R7: The entry delay is OFF_USB_CYC between all-off and either USB path, in either direction. It is AUD_USB1_CYC from audio or mute to USB path 1. It is DEF_CYC for every other transition.
- R9: A code that becomes steady while `busy_o` is high is held and committed on the first clock after `busy_o` falls. Only the latest steady code is kept.
- R10: `mode_o` takes the new mode on the clock at which the change is committed, which is the clock at which `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 2 | Asynchronous control code: bit 1 is the high select bit, bit 0 the low select bit |
| usb1_en_o | output | 1 | Closes USB path 1 |
| usb2_en_o | output | 1 | Closes USB path 2 |
| audio_en_o | output | 1 | Closes the stereo audio path |
| shunt_en_o | output | 1 | Connects the output shunt (mute) |
| mode_o | output | 3 | Mode being entered or held, encoded as in R2 |
| busy_o | output | 1 | High while a break interval or an entry delay is counting |

## Verification
Two functions can fall on the same clock. One is the stability filter accepting a new code. The other is the sequencer finishing an entry delay and dropping `busy_o`. The bench provokes this overlap by starting a transition and then changing the code after a delay that it sweeps one clock at a time, so that acceptance lands before, on and after the clock at which the delay ends. A behavioural model with a queued synchronizer and integer countdowns predicts every output, and the outputs are compared with it on every clock. Separate checks confirm that a code accepted during a change is committed exactly one clock after `busy_o` falls.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_USB1  = 3'd1,
    MODE_USB2  = 3'd2,
    MODE_AUDIO = 3'd3,
    MODE_MUTE  = 3'd4
  } mode_t;

  // enable vector bit positions
  localparam int EN_USB1  = 0;
  localparam int EN_USB2  = 1;
  localparam int EN_AUDIO = 2;
  localparam int EN_SHUNT = 3;
  localparam int EN_W     = 4;

  // code 10 is resolved by the history bit
  function automatic mode_t code_to_mode(input logic [1:0] code, input logic hist);
    case (code)
      2'b00:   return MODE_OFF;
      2'b01:   return MODE_USB1;
      2'b11:   return MODE_AUDIO;
      default: return hist ? MODE_MUTE : MODE_USB2;
    endcase
  endfunction

  function automatic logic [EN_W-1:0] mode_enables(input mode_t m);
    logic [EN_W-1:0] e;
    e = '0;
    case (m)
      MODE_USB1:  e[EN_USB1]  = 1'b1;
      MODE_USB2:  e[EN_USB2]  = 1'b1;
      MODE_AUDIO: e[EN_AUDIO] = 1'b1;
      MODE_MUTE:  e[EN_SHUNT] = 1'b1;
      default:    e = '0;
    endcase
    return e;
  endfunction

  function automatic logic is_usb(input mode_t m);
    return (m == MODE_USB1) || (m == MODE_USB2);
  endfunction

endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cmc_settle.sv
module cmc_settle #(
  parameter int W        = 2,
  parameter int HOLD_CYC = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);

  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [W-1:0]  cand_q;
  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      age_q  <= '0;
      code_o <= '0;
    end else if (code_i != cand_q) begin
      cand_q <= code_i;
      age_q  <= '0;
    end else if (age_q != LAST) begin
      age_q <= age_q + 1'b1;
    end else begin
      code_o <= cand_q;
    end
  end

endmodule

// File: rtl/cmc_seq.sv
module cmc_seq
  import cmc_pkg::*;
#(
  parameter int BREAK_CYC    = 5,
  parameter int OFF_USB_CYC  = 18,
  parameter int AUD_USB1_CYC = 1200,
  parameter int DEF_CYC      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      code_i,
  output logic [EN_W-1:0] en_o,
  output mode_t           mode_o,
  output logic            busy_o
);

  localparam int MAX_A = (BREAK_CYC > OFF_USB_CYC) ? BREAK_CYC : OFF_USB_CYC;
  localparam int MAX_B = (AUD_USB1_CYC > DEF_CYC) ? AUD_USB1_CYC : DEF_CYC;
  localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXD + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_BREAK, PH_ENTRY} phase_t;

  phase_t        phase_q;
  logic [CW-1:0] cnt_q, entry_q, entry_len;
  logic [1:0]    applied_q;
  logic          hist_q;
  mode_t         nxt_mode;

  assign nxt_mode = code_to_mode(code_i, hist_q);

  always_comb begin
    if ((mode_o == MODE_OFF && is_usb(nxt_mode)) || (is_usb(mode_o) && nxt_mode == MODE_OFF))
      entry_len = CW'(OFF_USB_CYC - 1);
    else if ((mode_o == MODE_AUDIO || mode_o == MODE_MUTE) && nxt_mode == MODE_USB1)
      entry_len = CW'(AUD_USB1_CYC - 1);
    else
      entry_len = CW'(DEF_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      entry_q   <= '0;
      applied_q <= 2'b00;
      hist_q    <= 1'b0;
      mode_o    <= MODE_OFF;
      en_o      <= '0;
      busy_o    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (code_i != applied_q) begin
          applied_q <= code_i;
          mode_o    <= nxt_mode;
          hist_q    <= (nxt_mode == MODE_AUDIO) || (nxt_mode == MODE_MUTE);
          en_o      <= '0;
          busy_o    <= 1'b1;
          cnt_q     <= CW'(BREAK_CYC - 1);
          entry_q   <= entry_len;
          phase_q   <= PH_BREAK;
        end
        PH_BREAK: if (cnt_q == '0) begin
          cnt_q   <= entry_q;
          phase_q <= PH_ENTRY;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: if (cnt_q == '0) begin
          en_o    <= mode_enables(mode_o);
          busy_o  <= 1'b0;
          phase_q <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/conn_mode_ctrl.sv
module conn_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SKEW_CYC     = 10,
  parameter int BREAK_CYC    = 5,
  parameter int OFF_USB_CYC  = 18,
  parameter int AUD_USB1_CYC = 1200,
  parameter int DEF_CYC      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ctl_i,
  output logic       usb1_en_o,
  output logic       usb2_en_o,
  output logic       audio_en_o,
  output logic       shunt_en_o,
  output logic [2:0] mode_o,
  output logic       busy_o
);

  logic [1:0]      code_sync, code_steady;
  logic [EN_W-1:0] en;
  mode_t           mode;

  cmc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(ctl_i), .q_o(code_sync)
  );

  cmc_settle #(.W(2), .HOLD_CYC(SKEW_CYC)) u_settle (
    .clk(clk), .rst(rst), .code_i(code_sync), .code_o(code_steady)
  );

  cmc_seq #(
    .BREAK_CYC(BREAK_CYC), .OFF_USB_CYC(OFF_USB_CYC),
    .AUD_USB1_CYC(AUD_USB1_CYC), .DEF_CYC(DEF_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .code_i(code_steady),
    .en_o(en), .mode_o(mode), .busy_o(busy_o)
  );

  assign usb1_en_o  = en[EN_USB1];
  assign usb2_en_o  = en[EN_USB2];
  assign audio_en_o = en[EN_AUDIO];
  assign shunt_en_o = en[EN_SHUNT];
  assign mode_o     = mode;

endmodule

// File: rtl/cmc_checks.sv
module cmc_checks (
  input logic       clk,
  input logic       rst,
  input logic       usb1_en_o,
  input logic       usb2_en_o,
  input logic       audio_en_o,
  input logic       shunt_en_o,
  input logic [2:0] mode_o,
  input logic       busy_o
);

  logic [3:0] en;
  assign en = {shunt_en_o, audio_en_o, usb2_en_o, usb1_en_o};

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en)); // R4
  AST_SHUNT_ONLY_MUTE: assert property (@(posedge clk) disable iff (rst)
    shunt_en_o |-> mode_o == 3'd4); // R4
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> en == 4'b0000); // R6
  AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (rst)
    (en != 4'b0000 && !$stable(en)) |-> $past(en) == 4'b0000); // R6
  AST_MUTE_FROM_AUDIO: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mode_o) && mode_o == 3'd4) |-> $past(mode_o) == 3'd3); // R3
  AST_USB2_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mode_o) && mode_o == 3'd2) |-> ($past(mode_o) == 3'd0 || $past(mode_o) == 3'd1)); // R3
  AST_MODE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_o) |-> $rose(busy_o)); // R10
  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd4); // R2

endmodule

bind conn_mode_ctrl cmc_checks u_checks (
  .clk(clk), .rst(rst), .usb1_en_o(usb1_en_o), .usb2_en_o(usb2_en_o),
  .audio_en_o(audio_en_o), .shunt_en_o(shunt_en_o), .mode_o(mode_o), .busy_o(busy_o)
);

// File: tb/conn_mode_ctrl_test.sv
`timescale 1ns/1ps
module conn_mode_ctrl_test;

  localparam int SKEW = 10, BRK = 5, OFFUSB = 18, AUDUSB = 1200, DEFD = 2;

  logic clk = 0, rst = 1;
  logic [1:0] ctl = 2'b00;
  logic usb1, usb2, aud, shunt, busy;
  logic [2:0] mode;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  always #5 clk = ~clk;

  conn_mode_ctrl #(.SKEW_CYC(SKEW), .BREAK_CYC(BRK), .OFF_USB_CYC(OFFUSB),
                   .AUD_USB1_CYC(AUDUSB), .DEF_CYC(DEFD)) uut (
    .clk(clk), .rst(rst), .ctl_i(ctl), .usb1_en_o(usb1), .usb2_en_o(usb2),
    .audio_en_o(aud), .shunt_en_o(shunt), .mode_o(mode), .busy_o(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int sq[$];
  int cand, age, acc, applied, m_mode, hist, m_busy, left, m_en;

  function automatic int dec(int code, int h);
    case (code)
      0: return 0;
      1: return 1;
      3: return 3;
      default: return h ? 4 : 2;
    endcase
  endfunction

  function automatic int en_of(int m);
    case (m)
      1: return 1; 2: return 2; 3: return 4; 4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int dly(int o, int n);
    if ((o == 0 && (n == 1 || n == 2)) || ((o == 1 || o == 2) && n == 0)) return OFFUSB;
    if ((o == 3 || o == 4) && n == 1) return AUDUSB;
    return DEFD;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      sq = '{0, 0};
      cand = 0; age = 1; acc = 0; applied = 0;
      m_mode = 0; hist = 0; m_busy = 0; left = 0; m_en = 0;
      started = 1;
    end else begin
      int cs, nm;
      if (m_busy != 0) begin
        left--;
        if (left == 0) begin m_busy = 0; m_en = en_of(m_mode); end
      end else if (acc != applied) begin
        nm = dec(acc, hist);
        left = BRK + dly(m_mode, nm);
        m_mode = nm; hist = (nm >= 3); applied = acc; m_en = 0; m_busy = 1;
      end
      cs = sq[0];
      if (cs != cand) begin cand = cs; age = 1; end
      else if (age <= SKEW) age++;
      if (age == SKEW + 1) acc = cand;
      sq.push_back(int'(ctl));
      void'(sq.pop_front());
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk({shunt, aud, usb2, usb1} == 4'(m_en), "R6 enables vs model", int'({shunt, aud, usb2, usb1}), m_en);
      chk(int'(mode) == m_mode, "R10 mode_o vs model", int'(mode), m_mode);
      chk(int'(busy) == m_busy, "R9 busy_o vs model", int'(busy), m_busy);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic drive(input logic [1:0] c);
    @(negedge clk); ctl = c;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for busy to rise, returns the number of samples it stays high
  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic expect_state(input string tag, input int m, input int e);
    chk(int'(mode) == m, {tag, " mode_o"}, int'(mode), m);
    chk(int'({shunt, aud, usb2, usb1}) == e, {tag, " enables"}, int'({shunt, aud, usb2, usb1}), e);
    chk(busy == 1'b0, {tag, " busy_o"}, int'(busy), 0);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_state("R1 reset", 0, 0);

    drive(2'b01); busy_len(n);
    chk(n == BRK + OFFUSB, "R7 off->usb1 delay", n, BRK + OFFUSB);
    expect_state("R2 usb1", 1, 1);

    drive(2'b00); busy_len(n);
    chk(n == BRK + OFFUSB, "R7 usb1->off delay", n, BRK + OFFUSB);
    expect_state("R2 off", 0, 0);

    drive(2'b10); busy_len(n);
    expect_state("R3 usb2 with history clear", 2, 2);

    drive(2'b00); wait_n(60);
    drive(2'b11); busy_len(n);
    chk(n == BRK + DEFD, "R7 off->audio delay", n, BRK + DEFD);
    expect_state("R2 audio", 3, 4);

    drive(2'b10); busy_len(n);
    expect_state("R4 mute shunt", 4, 8);
    wait_n(60);
    expect_state("R3 mute held on code 10", 4, 8);

    drive(2'b01); busy_len(n);
    chk(n == BRK + AUDUSB, "R7 mute->usb1 delay", n, BRK + AUDUSB);
    expect_state("R7 usb1 after mute", 1, 1);

    // short glitch must not be acted on
    drive(2'b00); wait_n(SKEW - 2); drive(2'b01);
    seen = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R5 glitch ignored busy", int'(seen), 0);
    expect_state("R5 glitch ignored", 1, 1);

    // skewed change 00 -> 11 via 10 must not visit usb2
    drive(2'b00); wait_n(60);
    drive(2'b10); wait_n(SKEW / 2); drive(2'b11);
    seen = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (mode == 3'd2) seen = 1; end
    chk(!seen, "R5 skewed code not decoded", int'(seen), 0);
    expect_state("R5 landed in audio", 3, 4);

    // history cleared through all-off
    drive(2'b00); wait_n(60);
    drive(2'b10); wait_n(80);
    expect_state("R3 usb2 after audio via off", 2, 2);

    // code latched during busy
    drive(2'b00); wait_n(60);
    drive(2'b01);
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    drive(2'b11);
    while (busy) @(negedge clk);
    n = 0;
    while (!busy && n < 50) begin n++; @(negedge clk); end
    chk(n == 1, "R9 pending code committed next clock", n, 1);
    wait_n(40);
    expect_state("R9 pending audio applied", 3, 4);

    // sweep code change against end of entry delay
    drive(2'b00); wait_n(60);
    for (int k = 0; k < 26; k++) begin
      drive(2'b01); wait_n(k); drive(2'b00); wait_n(90);
    end
    expect_state("R6 sweep ends in off", 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule